// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block guards test and readback access to a configuration store, a bank of output registers and a 64-bit user signature. A single command port carries an opcode, an address and a byte of write data; each accepted command produces one response beat a cycle later, carrying read data and an error flag. Three kinds of access are offered. A register can be forced to a chosen high or low value. A configuration word can be read back. A byte of the signature can be read or written.

A sticky security lock, loaded from the nonvolatile lock state while reset is held, refuses register preload and configuration readback as soon as it is set. The signature stays reachable while the lock is set. Only the erase command clears the lock, and erase also wipes the configuration store while keeping the signature. Outside of preload, the output registers follow a functional next-state input whenever the functional enable is high. A preload of one register overrides that update for that bit in the same cycle.

The command sequencer has two states. In `ST_IDLE` the port is ready, and a valid command moves it to `ST_EXEC` (transition ACCEPT). In `ST_EXEC` the latched command takes effect and the response is registered, and the sequencer returns unconditionally to `ST_IDLE` (transition RETIRE).

Top module: `scac_top`

## Requirements
- R1: While reset is low and at its release, `regs_o` is all zero, `rsp_valid_o` and `rsp_err_o` are 0, and `cmd_ready_o` is 1. The configuration store takes `cfg_image_i` (word w at bits w*DATA_W upward), and the lock takes `lock_init_i`.
- R2: A command is accepted on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `cmd_ready_o` is 0 for the following cycle. `rsp_valid_o` is 1 for exactly the cycle after the next edge, and that edge is where the command takes effect.
- R3: Opcode 0 (preload) with address below NUM_REGS, write data 0 or 1, and the lock clear sets `regs_o[addr]` to write data bit 0.
- R4: When a preload takes effect on the same edge as `func_en_i`=1, the preloaded bit takes the preload value and every other bit takes `func_next_i`.
- R5: On an edge with no preload taking effect, `regs_o` loads `func_next_i` if `func_en_i` is 1 and holds otherwise.
- R6: Opcode 1 (configuration read) with address below CFG_WORDS and the lock clear returns the stored word in `rsp_data_o`.
- R7: Opcode 2 writes write data to signature byte addr, and opcode 3 returns signature byte addr in `rsp_data_o[7:0]` with the upper bits zero. Both need address below 8 and ignore the lock. The signature is zero after reset.
- R8: Opcode 4 sets the lock. Every later preload or configuration read, starting with the very next command, is refused.
- R9: With the lock set, signature reads and writes still succeed.
- R10: Opcode 5 (erase) clears every configuration word to zero and clears the lock, and it leaves the signature unchanged.
- R11: A refused command returns `rsp_err_o`=1 and `rsp_data_o`=0 and changes no state. Opcodes 6 and 7, out-of-range addresses, and preload data above 1 are refused.
- R12: `rsp_err_o` is 1 only together with `rsp_valid_o` and lasts one cycle. A successful write, lock or erase responds with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_init_i | input | 1 | Nonvolatile lock state, sampled while reset is low |
| cfg_image_i | input | CFG_WORDS*DATA_W | Nonvolatile configuration contents, sampled while reset is low |
| func_en_i | input | 1 | Functional update enable for the output registers |
| func_next_i | input | NUM_REGS | Functional next state of the output registers |
| regs_o | output | NUM_REGS | Output register bank |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command port can accept |
| cmd_op_i | input | 3 | Opcode |
| cmd_addr_i | input | ADDR_W | Register index, word index or byte index |
| cmd_wdata_i | input | 8 | Preload value or signature byte |
| rsp_valid_o | output | 1 | Response beat |
| rsp_err_o | output | 1 | Command refused |
| rsp_data_o | output | DATA_W | Read data, zero unless a read succeeded |

## Verification
The assertions assume that `func_en_i` and `func_next_i` hold known values at every edge. They also assume that `cfg_image_i` and `lock_init_i` are settled before reset is released. The properties on register holding and loading depend on a preload never taking effect on an edge that follows a ready cycle. The bench drives every input half a cycle away from the active edge. It keeps the image and lock inputs fixed across each reset, and it raises `cmd_valid_i` only while the port is ready. It also raises the functional enable in the execute cycle of a preload on purpose, to exercise the override.

// File: rtl/scac_pkg.sv
package scac_pkg;

    // Opcode encodings decoded by the command sequencer.
    localparam logic [2:0] OP_PRELOAD  = 3'd0;
    localparam logic [2:0] OP_RD_CFG   = 3'd1;
    localparam logic [2:0] OP_WR_SIG   = 3'd2;
    localparam logic [2:0] OP_RD_SIG   = 3'd3;
    localparam logic [2:0] OP_SET_LOCK = 3'd4;
    localparam logic [2:0] OP_ERASE    = 3'd5;

    // 64-bit user signature held as bytes.
    localparam int SIG_BYTES = 8;
    localparam int SIG_IW    = $clog2(SIG_BYTES);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } scac_state_e;

endpackage

// File: rtl/scac_cmd_fsm.sv
module scac_cmd_fsm
    import scac_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int NUM_REGS  = 10,
    parameter int CFG_WORDS = 8,
    parameter int REG_IW    = $clog2(NUM_REGS),
    parameter int CFG_AW    = $clog2(CFG_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [2:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [7:0]        cmd_wdata_i,
    input  logic              locked_i,
    input  logic [DATA_W-1:0] cfg_rdata_i,
    input  logic [7:0]        sig_rdata_i,
    output logic [REG_IW-1:0] reg_idx_o,
    output logic [CFG_AW-1:0] cfg_idx_o,
    output logic [SIG_IW-1:0] sig_idx_o,
    output logic              pre_val_o,
    output logic [7:0]        sig_wdata_o,
    output logic              preload_o,
    output logic              sig_wr_o,
    output logic              lock_set_o,
    output logic              erase_o,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [DATA_W-1:0] rsp_data_o
);

    localparam logic [ADDR_W-1:0] REG_LIM = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] CFG_LIM = ADDR_W'(CFG_WORDS);
    localparam logic [ADDR_W-1:0] SIG_LIM = ADDR_W'(SIG_BYTES);

    scac_state_e       state_q, state_d;
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic              exec;
    logic              cmd_ok;
    logic              dec_pre, dec_sw, dec_lock, dec_erase;
    logic [DATA_W-1:0] rd_val;
    logic              rsp_valid_q, rsp_err_q;
    logic [DATA_W-1:0] rsp_data_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT (IDLE->EXEC), RETIRE (EXEC->IDLE).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid_i) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Command capture on ACCEPT.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && cmd_valid_i) begin
            op_q    <= cmd_op_i;
            addr_q  <= cmd_addr_i;
            wdata_q <= cmd_wdata_i;
        end
    end

    assign exec = (state_q == ST_EXEC);

    // Opcode decode and permission check.
    always_comb begin
        cmd_ok    = 1'b0;
        dec_pre   = 1'b0;
        dec_sw    = 1'b0;
        dec_lock  = 1'b0;
        dec_erase = 1'b0;
        rd_val    = '0;
        unique case (op_q)
            OP_PRELOAD: begin
                if (addr_q < REG_LIM && wdata_q[7:1] == 7'd0 && !locked_i) begin
                    cmd_ok  = 1'b1;
                    dec_pre = 1'b1;
                end
            end
            OP_RD_CFG: begin
                if (addr_q < CFG_LIM && !locked_i) begin
                    cmd_ok = 1'b1;
                    rd_val = cfg_rdata_i;
                end
            end
            OP_WR_SIG: begin
                if (addr_q < SIG_LIM) begin
                    cmd_ok = 1'b1;
                    dec_sw = 1'b1;
                end
            end
            OP_RD_SIG: begin
                if (addr_q < SIG_LIM) begin
                    cmd_ok = 1'b1;
                    rd_val = DATA_W'(sig_rdata_i);
                end
            end
            OP_SET_LOCK: begin
                cmd_ok   = 1'b1;
                dec_lock = 1'b1;
            end
            OP_ERASE: begin
                cmd_ok    = 1'b1;
                dec_erase = 1'b1;
            end
            default: cmd_ok = 1'b0;
        endcase
    end

    assign preload_o   = exec && dec_pre;
    assign sig_wr_o    = exec && dec_sw;
    assign lock_set_o  = exec && dec_lock;
    assign erase_o     = exec && dec_erase;
    assign reg_idx_o   = addr_q[REG_IW-1:0];
    assign cfg_idx_o   = addr_q[CFG_AW-1:0];
    assign sig_idx_o   = addr_q[SIG_IW-1:0];
    assign pre_val_o   = wdata_q[0];
    assign sig_wdata_o = wdata_q;

    // Output process: ready from state, response registered in EXEC.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= exec;
            rsp_err_q   <= exec && !cmd_ok;
            rsp_data_q  <= (exec && cmd_ok) ? rd_val : '0;
        end
    end

    assign cmd_ready_o = (state_q == ST_IDLE);
    assign rsp_valid_o = rsp_valid_q;
    assign rsp_err_o   = rsp_err_q;
    assign rsp_data_o  = rsp_data_q;

endmodule

// File: rtl/scac_store.sv
module scac_store
    import scac_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CFG_WORDS = 8,
    parameter int CFG_AW    = $clog2(CFG_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CFG_WORDS*DATA_W-1:0] cfg_image_i,
    input  logic                        lock_init_i,
    input  logic [CFG_AW-1:0]           cfg_idx_i,
    input  logic [SIG_IW-1:0]           sig_idx_i,
    input  logic                        sig_wr_i,
    input  logic [7:0]                  sig_wdata_i,
    input  logic                        lock_set_i,
    input  logic                        erase_i,
    output logic                        locked_o,
    output logic [DATA_W-1:0]           cfg_rdata_o,
    output logic [7:0]                  sig_rdata_o
);

    logic [CFG_WORDS-1:0][DATA_W-1:0] cfg_words;
    logic [7:0] sig_q [SIG_BYTES];
    logic       lock_q;

    for (genvar w = 0; w < CFG_WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       word_q <= cfg_image_i[w*DATA_W +: DATA_W];
            else if (erase_i) word_q <= '0;
        end
        assign cfg_words[w] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lock_q <= lock_init_i;
        else if (erase_i)    lock_q <= 1'b0;
        else if (lock_set_i) lock_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < SIG_BYTES; b++) sig_q[b] <= '0;
        end else if (sig_wr_i) begin
            sig_q[sig_idx_i] <= sig_wdata_i;
        end
    end

    assign locked_o    = lock_q;
    assign cfg_rdata_o = cfg_words[cfg_idx_i];
    assign sig_rdata_o = sig_q[sig_idx_i];

endmodule

// File: rtl/scac_reg_bank.sv
module scac_reg_bank #(
    parameter int NUM_REGS = 10,
    parameter int REG_IW   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                preload_i,
    input  logic [REG_IW-1:0]   preload_idx_i,
    input  logic                preload_val_i,
    input  logic                func_en_i,
    input  logic [NUM_REGS-1:0] func_next_i,
    output logic [NUM_REGS-1:0] regs_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
        logic bit_q;
        logic hit;
        assign hit = preload_i && (preload_idx_i == REG_IW'(g));
        // Preload wins over the functional update of the same bit.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         bit_q <= 1'b0;
            else if (hit)       bit_q <= preload_val_i;
            else if (func_en_i) bit_q <= func_next_i[g];
        end
        assign regs_o[g] = bit_q;
    end

endmodule

// File: rtl/scac_top.sv
module scac_top
    import scac_pkg::*;
#(
    parameter int NUM_REGS  = 10,
    parameter int CFG_WORDS = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lock_init_i,
    input  logic [CFG_WORDS*DATA_W-1:0] cfg_image_i,
    input  logic                        func_en_i,
    input  logic [NUM_REGS-1:0]         func_next_i,
    output logic [NUM_REGS-1:0]         regs_o,
    input  logic                        cmd_valid_i,
    output logic                        cmd_ready_o,
    input  logic [2:0]                  cmd_op_i,
    input  logic [ADDR_W-1:0]           cmd_addr_i,
    input  logic [7:0]                  cmd_wdata_i,
    output logic                        rsp_valid_o,
    output logic                        rsp_err_o,
    output logic [DATA_W-1:0]           rsp_data_o
);

    localparam int REG_IW = $clog2(NUM_REGS);
    localparam int CFG_AW = $clog2(CFG_WORDS);

    logic [REG_IW-1:0] reg_idx;
    logic [CFG_AW-1:0] cfg_idx;
    logic [SIG_IW-1:0] sig_idx;
    logic              pre_val, preload, sig_wr, lock_set, erase, locked;
    logic [7:0]        sig_wdata, sig_rdata;
    logic [DATA_W-1:0] cfg_rdata;

    scac_cmd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
        .CFG_WORDS(CFG_WORDS), .REG_IW(REG_IW), .CFG_AW(CFG_AW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
        .cmd_op_i(cmd_op_i), .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i),
        .locked_i(locked), .cfg_rdata_i(cfg_rdata), .sig_rdata_i(sig_rdata),
        .reg_idx_o(reg_idx), .cfg_idx_o(cfg_idx), .sig_idx_o(sig_idx),
        .pre_val_o(pre_val), .sig_wdata_o(sig_wdata),
        .preload_o(preload), .sig_wr_o(sig_wr), .lock_set_o(lock_set), .erase_o(erase),
        .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_data_o(rsp_data_o)
    );

    scac_store #(
        .DATA_W(DATA_W), .CFG_WORDS(CFG_WORDS), .CFG_AW(CFG_AW)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_image_i(cfg_image_i), .lock_init_i(lock_init_i),
        .cfg_idx_i(cfg_idx), .sig_idx_i(sig_idx),
        .sig_wr_i(sig_wr), .sig_wdata_i(sig_wdata),
        .lock_set_i(lock_set), .erase_i(erase),
        .locked_o(locked), .cfg_rdata_o(cfg_rdata), .sig_rdata_o(sig_rdata)
    );

    scac_reg_bank #(
        .NUM_REGS(NUM_REGS), .REG_IW(REG_IW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .preload_i(preload), .preload_idx_i(reg_idx), .preload_val_i(pre_val),
        .func_en_i(func_en_i), .func_next_i(func_next_i),
        .regs_o(regs_o)
    );

endmodule

// File: rtl/scac_chk.sv
module scac_chk #(
    parameter int NUM_REGS = 10,
    parameter int DATA_W   = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                func_en_i,
    input logic [NUM_REGS-1:0] func_next_i,
    input logic [NUM_REGS-1:0] regs_o,
    input logic                cmd_valid_i,
    input logic                cmd_ready_o,
    input logic                rsp_valid_o,
    input logic                rsp_err_o,
    input logic [DATA_W-1:0]   rsp_data_o
);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (regs_o == '0 && !rsp_valid_o && cmd_ready_o)); // R1
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o); // R2
    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid_i && cmd_ready_o) |=> ##1 rsp_valid_o); // R2
    AST_RSP_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid_o |=> !rsp_valid_o); // R2
    AST_FUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cmd_ready_o && !func_en_i) |=> $stable(regs_o)); // R5
    AST_FUNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (cmd_ready_o && func_en_i) |=> regs_o == $past(func_next_i)); // R5
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n) rsp_err_o |-> rsp_data_o == '0); // R11
    AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n) rsp_err_o |-> rsp_valid_o); // R12
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_err_o |=> !rsp_err_o); // R12

endmodule

bind scac_top scac_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .func_en_i(func_en_i), .func_next_i(func_next_i),
    .regs_o(regs_o), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_data_o(rsp_data_o)
);

// File: tb/scac_top_tb_top.sv
`timescale 1ns/1ps
module scac_top_tb_top;

    localparam int NR = 10;
    localparam int NW = 8;
    localparam int DW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           lock_init = 1'b0;
    logic [NW*DW-1:0] cfg_image;
    logic           func_en = 1'b0;
    logic [NR-1:0]  func_next = '0;
    logic [NR-1:0]  regs_o;
    logic           cmd_valid = 1'b0;
    logic           cmd_ready;
    logic [2:0]     cmd_op = '0;
    logic [7:0]     cmd_addr = '0;
    logic [7:0]     cmd_wdata = '0;
    logic           rsp_valid, rsp_err;
    logic [DW-1:0]  rsp_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    scac_top #(.NUM_REGS(NR), .CFG_WORDS(NW), .DATA_W(DW), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .lock_init_i(lock_init), .cfg_image_i(cfg_image),
        .func_en_i(func_en), .func_next_i(func_next), .regs_o(regs_o),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
        .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_data_o(rsp_data)
    );

    function automatic logic [15:0] img(int i);
        return 16'(16'hA000 + i * 16'h0357);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every clock.
    logic [NR-1:0] m_regs;
    logic [15:0]   m_store [NW];
    logic [7:0]    m_sig [8];
    logic          m_lock, m_busy, m_rv, m_err;
    logic [15:0]   m_data;
    logic [2:0]    p_op;
    logic [7:0]    p_addr, p_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_regs = '0; m_busy = 0; m_rv = 0; m_err = 0; m_data = '0;
            m_lock = lock_init;
            for (int i = 0; i < NW; i++) m_store[i] = img(i);
            for (int i = 0; i < 8; i++) m_sig[i] = '0;
        end else begin
            logic ok;
            logic [NR-1:0] nr;
            logic acc;
            acc = !m_busy && cmd_valid;
            nr = func_en ? func_next : m_regs;
            m_rv = 0; m_err = 0; m_data = '0; ok = 0;
            if (m_busy) begin
                m_rv = 1;
                case (p_op)
                    3'd0: if (p_addr < NR && p_data < 2 && !m_lock) begin ok = 1; nr[p_addr] = p_data[0]; end
                    3'd1: if (p_addr < NW && !m_lock) begin ok = 1; m_data = m_store[p_addr]; end
                    3'd2: if (p_addr < 8) begin ok = 1; m_sig[p_addr] = p_data; end
                    3'd3: if (p_addr < 8) begin ok = 1; m_data = {8'h00, m_sig[p_addr]}; end
                    3'd4: begin ok = 1; m_lock = 1; end
                    3'd5: begin ok = 1; m_lock = 0; for (int i = 0; i < NW; i++) m_store[i] = '0; end
                    default: ok = 0;
                endcase
                m_err = !ok;
            end
            m_regs = nr;
            m_busy = acc;
            if (acc) begin p_op = cmd_op; p_addr = cmd_addr; p_data = cmd_wdata; end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 regs_o vs model", 32'(regs_o), 32'(m_regs));
            chk("R2 cmd_ready_o vs model", 32'(cmd_ready), 32'(!m_busy));
            chk("R12 rsp_valid_o vs model", 32'(rsp_valid), 32'(m_rv));
            chk("R11 rsp_err_o vs model", 32'(rsp_err), 32'(m_err));
            chk("R7 rsp_data_o vs model", 32'(rsp_data), 32'(m_data));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    logic [15:0] rd;
    logic        er;

    // Called at a negedge with the port ready; returns the response beat.
    task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d,
                         input logic fe, input logic [NR-1:0] fn);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(posedge clk); @(negedge clk);
        cmd_valid = 0; func_en = fe; func_next = fn;
        @(posedge clk); @(negedge clk);
        func_en = 0;
        rd = rsp_data; er = rsp_err;
    endtask

    task automatic do_reset(input logic li);
        @(negedge clk);
        rst_n = 0; lock_init = li;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) cfg_image[i*DW +: DW] = img(i);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 regs_o in reset", 32'(regs_o), 0);
        chk("R1 ready in reset", 32'(cmd_ready), 1);
        rst_n = 1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);

        // R2: handshake timing
        cmd_valid = 1; cmd_op = 3'd3; cmd_addr = 8'd0; cmd_wdata = 0;
        @(posedge clk); @(negedge clk);
        cmd_valid = 0;
        chk("R2 ready low after accept", 32'(cmd_ready), 0);
        chk("R2 no rsp one cycle after accept", 32'(rsp_valid), 0);
        @(posedge clk); @(negedge clk);
        chk("R2 rsp two edges after accept", 32'(rsp_valid), 1);
        chk("R7 signature zero after reset", 32'(rsp_data), 0);

        // R6: configuration readback
        issue(3'd1, 8'd0, 0, 0, '0); chk("R6 cfg word 0", 32'(rd), 32'(img(0)));
        issue(3'd1, 8'd3, 0, 0, '0); chk("R6 cfg word 3", 32'(rd), 32'(img(3)));
        issue(3'd1, 8'd7, 0, 0, '0); chk("R6 cfg word 7", 32'(rd), 32'(img(7)));

        // R3: preload high and low
        issue(3'd0, 8'd2, 8'd1, 0, '0); chk("R3 preload reg2 high", 32'(regs_o), 32'h004);
        issue(3'd0, 8'd9, 8'd1, 0, '0); chk("R3 preload reg9 high", 32'(regs_o), 32'h204);
        issue(3'd0, 8'd2, 8'd0, 0, '0); chk("R3 preload reg2 low", 32'(regs_o), 32'h200);

        // R5: functional update and hold
        func_en = 1; func_next = 10'h2A5;
        @(negedge clk); func_en = 0;
        chk("R5 functional load", 32'(regs_o), 32'h2A5);
        func_next = 10'h000;
        @(negedge clk);
        chk("R5 hold when enable low", 32'(regs_o), 32'h2A5);

        // R4: preload beats same-cycle functional update
        issue(3'd0, 8'd4, 8'd0, 1, 10'h3FF); chk("R4 preload priority", 32'(regs_o), 32'h3EF);

        // R7: signature write and read
        for (int b = 0; b < 8; b++) issue(3'd2, 8'(b), 8'(8'h31 + b * 8'h17), 0, '0);
        chk("R12 write returns zero data", 32'(rd), 0);
        issue(3'd3, 8'd5, 0, 0, '0); chk("R7 sig byte 5", 32'(rd), 32'(8'(8'h31 + 5 * 8'h17)));
        issue(3'd3, 8'd0, 0, 0, '0); chk("R7 sig byte 0", 32'(rd), 32'h31);

        // R11: refusals
        issue(3'd6, 8'd0, 0, 0, '0); chk("R11 opcode 6 err", 32'(er), 1);
        chk("R11 opcode 6 data", 32'(rd), 0);
        @(negedge clk); chk("R12 err lasts one cycle", 32'(rsp_err), 0);
        issue(3'd7, 8'd0, 0, 0, '0); chk("R11 opcode 7 err", 32'(er), 1);
        issue(3'd1, 8'd8, 0, 0, '0); chk("R11 cfg addr 8 err", 32'(er), 1);
        issue(3'd0, 8'd10, 8'd1, 0, '0); chk("R11 preload addr 10 err", 32'(er), 1);
        chk("R11 preload addr 10 no effect", 32'(regs_o), 32'h3EF);
        issue(3'd0, 8'd4, 8'd2, 0, '0); chk("R11 preload data 2 err", 32'(er), 1);
        chk("R11 preload data 2 no effect", 32'(regs_o), 32'h3EF);
        issue(3'd2, 8'd8, 8'hEE, 0, '0); chk("R11 sig addr 8 err", 32'(er), 1);

        // R8: lock, effective from the next command
        issue(3'd4, 8'd0, 0, 0, '0); chk("R8 set lock ok", 32'(er), 0);
        issue(3'd1, 8'd0, 0, 0, '0); chk("R8 cfg read refused", 32'(er), 1);
        chk("R8 refused data zero", 32'(rd), 0);
        issue(3'd0, 8'd4, 8'd1, 0, '0); chk("R8 preload refused", 32'(er), 1);
        chk("R8 preload no effect", 32'(regs_o), 32'h3EF);

        // R9: signature still open while locked
        issue(3'd3, 8'd5, 0, 0, '0); chk("R9 sig read locked", 32'(rd), 32'(8'(8'h31 + 5 * 8'h17)));
        issue(3'd2, 8'd1, 8'h5A, 0, '0); chk("R9 sig write locked", 32'(er), 0);
        issue(3'd3, 8'd1, 0, 0, '0); chk("R9 sig readback locked", 32'(rd), 32'h5A);

        // R10: erase
        issue(3'd5, 8'd0, 0, 0, '0); chk("R10 erase ok", 32'(er), 0);
        issue(3'd1, 8'd3, 0, 0, '0); chk("R10 cfg cleared", 32'(rd), 0);
        chk("R10 lock cleared", 32'(er), 0);
        issue(3'd0, 8'd4, 8'd1, 0, '0); chk("R10 preload after erase", 32'(regs_o), 32'h3FF);
        issue(3'd3, 8'd1, 0, 0, '0); chk("R10 signature kept", 32'(rd), 32'h5A);

        // R1/R8: lock loaded from nonvolatile state at reset
        do_reset(1'b1);
        @(negedge clk);
        chk("R1 regs cleared by reset", 32'(regs_o), 0);
        issue(3'd1, 8'd2, 0, 0, '0); chk("R8 lock from reset refuses", 32'(er), 1);
        issue(3'd3, 8'd1, 0, 0, '0); chk("R1 signature cleared by reset", 32'(rd), 0);
        issue(3'd5, 8'd0, 0, 0, '0);
        issue(3'd1, 8'd2, 0, 0, '0); chk("R10 erase after locked reset", 32'(rd), 0);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule